// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block produces the feedback and reference pulses that a phase detector compares in a frequency synthesizer. The feedback path divides a fast input clock by a programmable total ratio. A dual-modulus prescaler, modelled in logic, divides by P or P+1. It is steered by two 6-bit counters: a swallow count and a program count. Each output cycle spans `program` prescaler cycles. The first `swallow` of them divide by P+1 and the rest divide by P, so the total ratio is P·program + swallow. The prescaler base P is selected by a mode pin and takes one of two values, 32 (divide 32/33) or 64 (divide 64/65) by default.

A second 6-bit counter divides the oscillator. The oscillator arrives as a one-clock strobe in the same clock domain, and the counter emits one reference pulse every `ref` strobes. New ratios are written into shadow registers and checked there. A value that breaks the ratio rules is refused and flagged. Accepted values, and a changed mode, take effect only when the running division cycle ends, so no cycle ever mixes two ratios.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is high, `fb_pulse`, `ref_pulse` and `cfg_err` are 0. After reset the ratios are swallow 0, program 3, ref 3 and base P_LO, so the first `fb_pulse` comes 3·P_LO clocks after reset is released.
- R2: With `mode_sel` = 0, the spacing between `fb_pulse` pulses is P_LO·program + swallow clocks.
- R3: With `mode_sel` = 1, the spacing between `fb_pulse` pulses is P_HI·program + swallow clocks.
- R4: The ratio holds at the corners swallow = 0 and swallow = program, for program values from 3 up to 63.
- R5: `fb_pulse` is high for exactly one clock per division cycle.
- R6: `ref_pulse` comes once every `ref_in` strobes of `osc_tick`. Clocks without a strobe do not advance the reference count.
- R7: A write, or a change of `mode_sel`, during a division cycle leaves that cycle at the old ratio. The next cycle uses the new one.
- R8: A feedback write with program < swallow or program < 3 raises `cfg_err` for one clock, in the clock after the write. The previous feedback ratio stays in use.
- R9: A reference write with ref < 3 raises `cfg_err` for one clock, in the clock after the write. The previous reference ratio stays in use.
- R10: `ref_pulse` is high for exactly one clock per reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (VCO-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Prescaler base: 0 selects P_LO/P_LO+1, 1 selects P_HI/P_HI+1 |
| n_load | input | 1 | Write strobe for the feedback ratio |
| swallow_in | input | 6 | Swallow count written by `n_load` |
| program_in | input | 6 | Program count written by `n_load` |
| r_load | input | 1 | Write strobe for the reference ratio |
| ref_in | input | 6 | Reference ratio written by `r_load` |
| osc_tick | input | 1 | One-clock strobe per oscillator period |
| fb_pulse | output | 1 | Divided feedback pulse |
| ref_pulse | output | 1 | Divided reference pulse |
| cfg_err | output | 1 | Pulse marking a refused write |

## Verification
Some properties are checked on every clock. The shadow registers always hold a legal ratio, and a flagged write leaves them unchanged. The prescaler phase never passes its terminal value. The remaining program count never reaches zero and never falls below the swallow count. Both output pulses are one clock wide.

Other properties can only be shown by the bench's scenarios. These are the arithmetic of the total ratios, swept over every legal pair for small prescaler bases in both modes. The same goes for the reload-boundary timing of writes and mode changes, and for reference spacing under sparse oscillator strobes.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    localparam int CW = 6;
    localparam int MIN_PROG = 3;
    localparam int MIN_REF = 3;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic {
        MOD_LO = 1'b0,
        MOD_HI = 1'b1
    } pmode_t;

    typedef struct packed {
        cnt_t swal;
        cnt_t prog;
    } nratio_t;

    localparam nratio_t N_RESET = '{swal: cnt_t'(0), prog: cnt_t'(MIN_PROG)};
    localparam cnt_t R_RESET = cnt_t'(MIN_REF);

    function automatic logic nratio_ok(input nratio_t v);
        return (v.prog >= v.swal) && (v.prog >= cnt_t'(MIN_PROG));
    endfunction

    function automatic logic rratio_ok(input cnt_t v);
        return v >= cnt_t'(MIN_REF);
    endfunction

endpackage

// File: rtl/ratio_shadow.sv
module ratio_shadow
    import pswallow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    n_we,
    input  nratio_t n_in,
    input  logic    r_we,
    input  cnt_t    r_in,
    output nratio_t pend_n,
    output cnt_t    pend_r,
    output logic    err
);
    logic err_n, err_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_n <= N_RESET;
            pend_r <= R_RESET;
            err_n  <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            err_n <= n_we && !nratio_ok(n_in);
            err_r <= r_we && !rratio_ok(r_in);
            if (n_we && nratio_ok(n_in)) pend_n <= n_in;
            if (r_we && rratio_ok(r_in)) pend_r <= r_in;
        end
    end

    assign err = err_n | err_r;

    // shadow always holds a legal feedback ratio (R8)
    assert_pend_n_legal_R8: assert property (@(posedge clk) disable iff (rst)
        nratio_ok(pend_n));
    // shadow always holds a legal reference ratio (R9)
    assert_pend_r_legal_R9: assert property (@(posedge clk) disable iff (rst)
        rratio_ok(pend_r));
    // refused feedback write kept the old ratio (R8)
    assert_bad_n_kept_R8: assert property (@(posedge clk) disable iff (rst)
        err_n |-> $stable(pend_n));
    // refused reference write kept the old ratio (R9)
    assert_bad_r_kept_R9: assert property (@(posedge clk) disable iff (rst)
        err_r |-> $stable(pend_r));
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int P_LO = 32,
    parameter int P_HI = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_mod,
    input  logic swallow,
    output logic tc
);
    localparam int PW = $clog2(P_HI + 2);
    localparam logic [PW-1:0] LO_V = PW'(P_LO);
    localparam logic [PW-1:0] HI_V = PW'(P_HI);

    logic [PW-1:0] phase;
    logic [PW-1:0] base;
    logic [PW-1:0] limit;

    // modulus P+1 while swallowing, else P; phase runs 0..modulus-1
    always_comb begin
        base  = hi_mod ? HI_V : LO_V;
        limit = swallow ? base : base - PW'(1);
    end

    assign tc = (phase == limit);

    always_ff @(posedge clk) begin
        if (rst)     phase <= '0;
        else if (tc) phase <= '0;
        else         phase <= phase + PW'(1);
    end

    // phase never runs past the largest modulus (R3)
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
        phase <= HI_V);
    // prescaler restarts after each terminal count (R2)
    assert_phase_restart_R2: assert property (@(posedge clk) disable iff (rst)
        tc |=> (phase == '0));
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
    import pswallow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tc,
    input  pmode_t  mode_in,
    input  nratio_t pend_n,
    output logic    swallow,
    output logic    hi_mod,
    output logic    fb_pulse
);
    cnt_t   a_rem;
    cnt_t   b_rem;
    pmode_t mode_act;
    logic   last;

    assign swallow = (a_rem != '0);
    assign hi_mod  = (mode_act == MOD_HI);
    assign last    = (b_rem == cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rem    <= N_RESET.swal;
            b_rem    <= N_RESET.prog;
            mode_act <= MOD_LO;
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= 1'b0;
            if (tc) begin
                if (last) begin
                    a_rem    <= pend_n.swal;
                    b_rem    <= pend_n.prog;
                    mode_act <= mode_in;
                    fb_pulse <= 1'b1;
                end else begin
                    b_rem <= b_rem - cnt_t'(1);
                    if (swallow) a_rem <= a_rem - cnt_t'(1);
                end
            end
        end
    end

    // remaining program count never empties (R2)
    assert_prog_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        b_rem != '0);
    // swallowed cycles never outnumber remaining cycles (R4)
    assert_swal_le_prog_R4: assert property (@(posedge clk) disable iff (rst)
        a_rem <= b_rem);
    // feedback pulse is one clock wide (R5)
    assert_fb_single_R5: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);
    // mode only moves at a reload boundary (R7)
    assert_mode_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |-> $stable(mode_act));
endmodule

// File: rtl/ref_div.sv
module ref_div
    import pswallow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t pend_r,
    output logic ref_pulse
);
    cnt_t r_cnt;
    cnt_t r_act;
    logic wrap;

    assign wrap = tick && (r_cnt == r_act - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cnt     <= '0;
            r_act     <= R_RESET;
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= wrap;
            if (wrap) begin
                r_cnt <= '0;
                r_act <= pend_r;
            end else if (tick) begin
                r_cnt <= r_cnt + cnt_t'(1);
            end
        end
    end

    // count stays inside the active ratio (R6)
    assert_rcnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        r_cnt < r_act);
    // count frozen without an oscillator strobe (R6)
    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(r_cnt));
    // reference pulse is one clock wide (R10)
    assert_ref_single_R10: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import pswallow_pkg::*;
#(
    parameter int P_LO = 32,
    parameter int P_HI = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel,
    input  logic       n_load,
    input  logic [5:0] swallow_in,
    input  logic [5:0] program_in,
    input  logic       r_load,
    input  logic [5:0] ref_in,
    input  logic       osc_tick,
    output logic       fb_pulse,
    output logic       ref_pulse,
    output logic       cfg_err
);
    nratio_t n_wr, pend_n;
    cnt_t    pend_r;
    logic    tc, swallow, hi_mod;
    pmode_t  mode_in;

    assign n_wr    = '{swal: swallow_in, prog: program_in};
    assign mode_in = mode_sel ? MOD_HI : MOD_LO;

    ratio_shadow u_shadow (
        .clk(clk), .rst(rst),
        .n_we(n_load), .n_in(n_wr),
        .r_we(r_load), .r_in(ref_in),
        .pend_n(pend_n), .pend_r(pend_r), .err(cfg_err)
    );

    dm_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
        .clk(clk), .rst(rst),
        .hi_mod(hi_mod), .swallow(swallow), .tc(tc)
    );

    swallow_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tc(tc),
        .mode_in(mode_in), .pend_n(pend_n),
        .swallow(swallow), .hi_mod(hi_mod), .fb_pulse(fb_pulse)
    );

    ref_div u_ref (
        .clk(clk), .rst(rst), .tick(osc_tick),
        .pend_r(pend_r), .ref_pulse(ref_pulse)
    );

    // refused writes report in the clock after the strobe (R8)
    assert_err_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> ($past(n_load) || $past(r_load)));
endmodule

// File: tb/pswallow_div_bench.sv
module pswallow_div_bench;
    localparam int P_LO = 4;
    localparam int P_HI = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic n_load = 1'b0;
    logic [5:0] swallow_in = '0;
    logic [5:0] program_in = 6'd3;
    logic r_load = 1'b0;
    logic [5:0] ref_in = 6'd3;
    logic osc_tick = 1'b0;
    logic fb_pulse, ref_pulse, cfg_err;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int tick_gap = 0;
    int tick_ph = 0;

    always #2 clk = ~clk;

    pswallow_div #(.P_LO(P_LO), .P_HI(P_HI)) u_pswallow_div (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .n_load(n_load), .swallow_in(swallow_in), .program_in(program_in),
        .r_load(r_load), .ref_in(ref_in), .osc_tick(osc_tick),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (tick_gap == 0) begin
            osc_tick = 1'b0;
        end else if (tick_ph >= tick_gap - 1) begin
            osc_tick = 1'b1;
            tick_ph = 0;
        end else begin
            osc_tick = 1'b0;
            tick_ph++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_n(input int a, input int b, output bit err);
        @(negedge clk);
        swallow_in = 6'(a);
        program_in = 6'(b);
        n_load = 1'b1;
        @(negedge clk);
        n_load = 1'b0;
        err = cfg_err;
    endtask

    task automatic write_r(input int r, output bit err);
        @(negedge clk);
        ref_in = 6'(r);
        r_load = 1'b1;
        @(negedge clk);
        r_load = 1'b0;
        err = cfg_err;
    endtask

    task automatic wait_fb();
        do @(negedge clk); while (!fb_pulse);
    endtask

    task automatic wait_ref();
        do @(negedge clk); while (!ref_pulse);
    endtask

    // spacing to the next feedback pulse; also checks pulse width (R5)
    task automatic measure_fb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(fb_pulse == 1'b0, "R5", int'(fb_pulse), 0);
        end while (!fb_pulse);
    endtask

    task automatic measure_ref(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(ref_pulse == 1'b0, "R10", int'(ref_pulse), 0);
        end while (!ref_pulse);
    endtask

    function automatic int ratio(input int md, input int a, input int b);
        return (md != 0 ? P_HI : P_LO) * b + a;
    endfunction

    initial begin
        bit e;
        int n;
        int cur;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(fb_pulse == 0 && ref_pulse == 0 && cfg_err == 0, "R1",
            int'({fb_pulse, ref_pulse, cfg_err}), 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!fb_pulse && n < 1000);
        chk(n == 3 * P_LO, "R1", n, 3 * P_LO);

        // R2 / R3 / R4: sweep every legal pair for small program counts
        for (int md = 0; md < 2; md++) begin
            mode_sel = 1'(md);
            for (int b = 3; b <= 12; b++) begin
                for (int a = 0; a <= b; a++) begin
                    write_n(a, b, e);
                    wait_fb();
                    measure_fb(n);
                    chk(n == ratio(md, a, b), md != 0 ? "R3" : "R2", n, ratio(md, a, b));
                end
            end
        end

        // R4: extreme corners
        for (int md = 0; md < 2; md++) begin
            mode_sel = 1'(md);
            write_n(63, 63, e); wait_fb(); measure_fb(n);
            chk(n == ratio(md, 63, 63), "R4", n, ratio(md, 63, 63));
            write_n(0, 63, e); wait_fb(); measure_fb(n);
            chk(n == ratio(md, 0, 63), "R4", n, ratio(md, 0, 63));
            write_n(0, 3, e); wait_fb(); measure_fb(n);
            chk(n == ratio(md, 0, 3), "R4", n, ratio(md, 0, 3));
        end

        // R7: write and mode change mid-cycle keep the running ratio
        mode_sel = 1'b0;
        write_n(2, 5, e); wait_fb(); measure_fb(n);
        cur = ratio(0, 2, 5);
        wait_fb();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) begin
                swallow_in = 6'd7; program_in = 6'd9; n_load = 1'b1; mode_sel = 1'b1;
            end
            if (n == 4) n_load = 1'b0;
        end while (!fb_pulse);
        chk(n == cur, "R7", n, cur);
        measure_fb(n);
        chk(n == ratio(1, 7, 9), "R7", n, ratio(1, 7, 9));

        // R8: refused feedback writes
        cur = ratio(1, 7, 9);
        write_n(6, 5, e);
        chk(e == 1'b1, "R8", int'(e), 1);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
        wait_fb(); measure_fb(n);
        chk(n == cur, "R8", n, cur);
        write_n(0, 2, e);
        chk(e == 1'b1, "R8", int'(e), 1);
        wait_fb(); measure_fb(n);
        chk(n == cur, "R8", n, cur);
        write_n(4, 4, e);
        chk(e == 1'b0, "R8", int'(e), 0);

        // R6 / R10: reference spacing, dense then sparse strobes
        tick_gap = 1;
        for (int r = 3; r <= 63; r += 4) begin
            write_r(r, e);
            wait_ref(); measure_ref(n);
            chk(n == r, "R6", n, r);
        end
        tick_gap = 3;
        for (int r = 3; r <= 12; r++) begin
            write_r(r, e);
            wait_ref(); measure_ref(n);
            chk(n == 3 * r, "R6", n, 3 * r);
        end

        // R7: reference write mid-cycle
        wait_ref();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 2) begin ref_in = 6'd5; r_load = 1'b1; end
            if (n == 3) r_load = 1'b0;
        end while (!ref_pulse);
        chk(n == 36, "R7", n, 36);
        measure_ref(n);
        chk(n == 15, "R7", n, 15);

        // R9: refused reference write
        write_r(2, e);
        chk(e == 1'b1, "R9", int'(e), 1);
        wait_ref(); measure_ref(n);
        chk(n == 15, "R9", n, 15);
        write_r(0, e);
        chk(e == 1'b1, "R9", int'(e), 1);
        wait_ref(); measure_ref(n);
        chk(n == 15, "R9", n, 15);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule